// File: doc/BRIEF.md
# Tiled L2 Home-Slice Selector

On a tiled chip whose last-level cache is split into one slice per tile, every L2 request must be sent to exactly one slice. This block takes the requesting tile number, the physical address, a flag that marks instruction fetches, and the private/shared class bit that the translation buffer supplies. From these it computes the destination tile. It does this with one registered stage, and it never needs a second lookup.

The placement depends on the kind of access. Private data stay in the requester's own slice. Shared data are spread across all slices by the address bits just above the line offset, so each shared line has a single home. Instruction fetches are placed inside a cluster of four tiles: the local tile and its east, south and west neighbours on a wrapped (torus) grid. Every tile carries a two-bit rotation number, and the fetch goes to the cluster member whose rotation number equals two selected address bits. Neighbouring clusters overlap, and each slice serves the same subset of instruction lines for every cluster that contains it.

The grid size, the address width and the line size are parameters. The grid width must be a multiple of four and the grid height must be even, so that the rotation numbers stay consistent across the torus wrap.

Top module: `slice_sel_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dst_valid` is 0 and `dst_tile` is 0.
- R2: `dst_valid` in a cycle equals `req_valid` sampled at the previous rising clock edge, so the latency is fixed at one cycle.
- R3: A data request (`req_ifetch`=0) with `req_shared`=0 yields `dst_tile` equal to `req_tile`.
- R4: A data request with `req_shared`=1 yields `dst_tile` equal to address bits [9:6] (the slice number above the 6-bit line offset, with the default 16 tiles). The requesting tile has no effect.
- R5: When `req_ifetch`=1, the `req_shared` bit has no effect on the destination.
- R6: Tile number t has grid column x = t mod 4 and row y = t div 4 (default 4x4 grid). Its rotation number is (x + 2y) mod 4.
- R7: For an instruction fetch, the destination tile's rotation number equals address bits [7:6].
- R8: An instruction fetch's destination is one of four tiles: the requester, its east neighbour (x+1), its south neighbour (y+1) or its west neighbour (x-1). Coordinates wrap at the grid edges.
- R9: When `req_valid` is 0 at a clock edge, `dst_valid` becomes 0 and `dst_tile` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_tile | input | TILE_W (4) | Requesting tile number |
| req_addr | input | ADDR_W (40) | Physical byte address |
| req_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_shared | input | 1 | Page class for data: 1 = shared, 0 = private |
| dst_valid | output | 1 | Destination valid, one cycle after the request |
| dst_tile | output | TILE_W (4) | Destination slice (tile) number |

## Verification
The checker tests on every cycle the properties that hold for any request. These are the one-cycle valid latency, private data going to the local tile, shared data going to the address-selected slice, and instruction destinations carrying the rotation number named by the address. It also tests that instruction destinations are always a torus neighbour or the requester, and that the output holds when no request arrives. The assertions cannot show that the chosen neighbour is the right one, or that the edge wrap lands on the correct tile. The bench scenarios show these: they sweep every tile against every rotation target, and they drive explicit corner tiles at the grid edges, a shared fetch, and the reset values.

// File: rtl/slice_sel_pkg.sv
package slice_sel_pkg;
   // Rotation numbers for the four-tile instruction cluster
   localparam int unsigned ROT_W = 2;

   // Step from the requester's rotation number to the target's (modulo 4)
   typedef enum logic [ROT_W-1:0] {
      STEP_LOCAL = 2'd0,
      STEP_EAST  = 2'd1,
      STEP_SOUTH = 2'd2,
      STEP_WEST  = 2'd3
   } rot_step_e;

   typedef enum logic [1:0] {
      CLS_PRIVATE = 2'd0,
      CLS_SHARED  = 2'd1,
      CLS_INSTR   = 2'd2
   } access_cls_e;
endpackage

// File: rtl/slice_sel_coord.sv
module slice_sel_coord #(
   parameter int unsigned GRID_X = 4,
   parameter int unsigned GRID_Y = 4,
   localparam int unsigned XW     = $clog2(GRID_X),
   localparam int unsigned YW     = $clog2(GRID_Y),
   localparam int unsigned TILE_W = XW + YW
) (
   input  logic [TILE_W-1:0] tile,
   output logic [XW-1:0]     pos_x,
   output logic [YW-1:0]     pos_y,
   output logic [1:0]        rot_id
);
   import slice_sel_pkg::*;

   // Grid sides are powers of two, so column and row are plain bit fields
   assign pos_x = tile[XW-1:0];
   assign pos_y = tile[TILE_W-1:XW];

   // Rotation number (x + 2y) mod 4
   assign rot_id = pos_x[1:0] + {pos_y[0], 1'b0};
endmodule

// File: rtl/slice_sel_inst_route.sv
module slice_sel_inst_route #(
   parameter int unsigned GRID_X = 4,
   parameter int unsigned GRID_Y = 4,
   localparam int unsigned XW     = $clog2(GRID_X),
   localparam int unsigned YW     = $clog2(GRID_Y)
) (
   input  logic [XW-1:0] src_x,
   input  logic [YW-1:0] src_y,
   input  logic [1:0]    src_rot,
   input  logic [1:0]    tgt_rot,
   output logic [XW-1:0] dst_x,
   output logic [YW-1:0] dst_y
);
   import slice_sel_pkg::*;

   localparam logic [XW-1:0] X_LAST = XW'(GRID_X - 1);
   localparam logic [YW-1:0] Y_LAST = YW'(GRID_Y - 1);

   logic [XW-1:0] east_x, west_x;
   logic [YW-1:0] south_y;
   rot_step_e     step;

   // Torus neighbours with explicit wrap at the edges
   assign east_x  = (src_x == X_LAST) ? '0 : src_x + XW'(1);
   assign west_x  = (src_x == '0) ? X_LAST : src_x - XW'(1);
   assign south_y = (src_y == Y_LAST) ? '0 : src_y + YW'(1);

   assign step = rot_step_e'(tgt_rot - src_rot);

   always_comb begin
      dst_x = src_x;
      dst_y = src_y;
      unique case (step)
         STEP_LOCAL: ;
         STEP_EAST:  dst_x = east_x;
         STEP_SOUTH: dst_y = south_y;
         STEP_WEST:  dst_x = west_x;
         default:    ;
      endcase
   end
endmodule

// File: rtl/slice_sel_data_route.sv
module slice_sel_data_route #(
   parameter int unsigned ADDR_W   = 40,
   parameter int unsigned OFFSET_W = 6,
   parameter int unsigned TILE_W   = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [TILE_W-1:0] src_tile,
   input  logic              shared,
   output logic [TILE_W-1:0] dst_tile
);
   logic [TILE_W-1:0] home;

   // Slice count is a power of two: modulo is the field above the line offset
   assign home     = addr[OFFSET_W +: TILE_W];
   assign dst_tile = shared ? home : src_tile;
endmodule

// File: rtl/slice_sel_top.sv
module slice_sel_top #(
   parameter int unsigned GRID_X   = 4,
   parameter int unsigned GRID_Y   = 4,
   parameter int unsigned ADDR_W   = 40,
   parameter int unsigned LINE_B   = 64,
   localparam int unsigned XW       = $clog2(GRID_X),
   localparam int unsigned YW       = $clog2(GRID_Y),
   localparam int unsigned TILE_W   = XW + YW,
   localparam int unsigned OFFSET_W = $clog2(LINE_B)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [TILE_W-1:0] req_tile,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_ifetch,
   input  logic              req_shared,
   output logic              dst_valid,
   output logic [TILE_W-1:0] dst_tile
);
   import slice_sel_pkg::*;

   // Elaboration-time parameter checks
   initial begin : elab_checks
      if ((GRID_X % 4) != 0 || (1 << XW) != GRID_X)
         $fatal(1, "GRID_X must be a power of two and a multiple of 4");
      if (GRID_Y < 2 || (1 << YW) != GRID_Y)
         $fatal(1, "GRID_Y must be a power of two of at least 2");
      if ((1 << OFFSET_W) != LINE_B)
         $fatal(1, "LINE_B must be a power of two");
      if (ADDR_W < OFFSET_W + TILE_W)
         $fatal(1, "ADDR_W too narrow for offset and slice field");
   end

   logic [XW-1:0]     src_x, ins_x;
   logic [YW-1:0]     src_y, ins_y;
   logic [1:0]        src_rot;
   logic [TILE_W-1:0] data_dst, next_dst;
   access_cls_e       cls;

   slice_sel_coord #(.GRID_X(GRID_X), .GRID_Y(GRID_Y)) u_coord (
      .tile   (req_tile),
      .pos_x  (src_x),
      .pos_y  (src_y),
      .rot_id (src_rot)
   );

   slice_sel_inst_route #(.GRID_X(GRID_X), .GRID_Y(GRID_Y)) u_inst (
      .src_x   (src_x),
      .src_y   (src_y),
      .src_rot (src_rot),
      .tgt_rot (req_addr[OFFSET_W +: 2]),
      .dst_x   (ins_x),
      .dst_y   (ins_y)
   );

   slice_sel_data_route #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .TILE_W(TILE_W)) u_data (
      .addr     (req_addr),
      .src_tile (req_tile),
      .shared   (req_shared),
      .dst_tile (data_dst)
   );

   // Instruction fetches override the data page class
   assign cls = req_ifetch ? CLS_INSTR : (req_shared ? CLS_SHARED : CLS_PRIVATE);

   always_comb begin
      unique case (cls)
         CLS_INSTR: next_dst = {ins_y, ins_x};
         default:   next_dst = data_dst;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dst_valid <= 1'b0;
         dst_tile  <= '0;
      end else begin
         dst_valid <= req_valid;
         if (req_valid) dst_tile <= next_dst;
      end
   end
endmodule

// File: rtl/slice_sel_chk.sv
module slice_sel_chk #(
   parameter int unsigned GRID_X   = 4,
   parameter int unsigned GRID_Y   = 4,
   parameter int unsigned ADDR_W   = 40,
   parameter int unsigned OFFSET_W = 6,
   localparam int unsigned XW       = $clog2(GRID_X),
   localparam int unsigned YW       = $clog2(GRID_Y),
   localparam int unsigned TILE_W   = XW + YW
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [TILE_W-1:0] req_tile,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_ifetch,
   input logic              req_shared,
   input logic              dst_valid,
   input logic [TILE_W-1:0] dst_tile
);
   // Capture of the previous request, used for the cluster-membership check
   logic              q_seen, q_ifetch;
   logic [TILE_W-1:0] q_tile;
   logic [1:0]        q_rot;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_seen   <= 1'b0;
         q_ifetch <= 1'b0;
         q_tile   <= '0;
         q_rot    <= '0;
      end else begin
         q_seen   <= req_valid;
         q_ifetch <= req_ifetch;
         q_tile   <= req_tile;
         q_rot    <= req_addr[OFFSET_W +: 2];
      end
   end

   logic [XW-1:0] sx, dx;
   logic [YW-1:0] sy, dy;
   logic [1:0]    d_rot;
   logic          in_cluster;

   assign sx    = q_tile[XW-1:0];
   assign sy    = q_tile[TILE_W-1:XW];
   assign dx    = dst_tile[XW-1:0];
   assign dy    = dst_tile[TILE_W-1:XW];
   assign d_rot = dx[1:0] + {dy[0], 1'b0};
   assign in_cluster = (dx == sx && dy == sy) ||
                       (dy == sy && dx == sx + XW'(1)) ||
                       (dy == sy && dx == sx - XW'(1)) ||
                       (dx == sx && dy == sy + YW'(1));

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> !dst_valid && dst_tile == '0);

   a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dst_valid);

   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !dst_valid);

   a_r3_private_local: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ifetch && !req_shared |=> dst_tile == $past(req_tile));

   a_r4_shared_home: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ifetch && req_shared |=> dst_tile == $past(req_addr[OFFSET_W +: TILE_W]));

   a_r7_rot_match: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid && q_seen && q_ifetch |-> d_rot == q_rot);

   a_r8_in_cluster: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid && q_seen && q_ifetch |-> in_cluster);

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(dst_tile));
endmodule

bind slice_sel_top slice_sel_chk #(
   .GRID_X(GRID_X), .GRID_Y(GRID_Y), .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tile(req_tile),
   .req_addr(req_addr), .req_ifetch(req_ifetch), .req_shared(req_shared),
   .dst_valid(dst_valid), .dst_tile(dst_tile)
);

// File: tb/slice_sel_top_tb.sv
module slice_sel_top_tb_top;
   localparam int NV = 12;

   // Vector table: requester, address bits [9:6], ifetch, shared, expected tile
   localparam logic [3:0] V_TILE [NV] = '{4'd0, 4'd0, 4'd0, 4'd0, 4'd15, 4'd15,
                                          4'd15, 4'd15, 4'd6, 4'd9, 4'd2, 4'd0};
   localparam logic [3:0] V_SEL  [NV] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h1, 4'h2,
                                          4'h3, 4'h0, 4'h2, 4'h7, 4'hB, 4'hD};
   localparam logic       V_IF   [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                          1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
   localparam logic       V_SH   [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                          1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
   localparam logic [3:0] V_EXP  [NV] = '{4'd0, 4'd1, 4'd4, 4'd3, 4'd15, 4'd12,
                                          4'd3, 4'd14, 4'd10, 4'd9, 4'd11, 4'd1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_tile = '0;
   logic [39:0] req_addr = '0;
   logic        req_ifetch = 1'b0;
   logic        req_shared = 1'b0;
   logic        dst_valid;
   logic [3:0]  dst_tile;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   slice_sel_top dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tile(req_tile),
      .req_addr(req_addr), .req_ifetch(req_ifetch), .req_shared(req_shared),
      .dst_valid(dst_valid), .dst_tile(dst_tile)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Drive one request at the falling edge, sample just after the next rising edge
   task automatic send(input logic [3:0] t, input logic [3:0] sel, input logic ifc, input logic sh);
      @(negedge clk);
      req_valid  = 1'b1;
      req_tile   = t;
      req_addr   = 40'hA5_5A00_3000 | {30'd0, sel, 6'h15};
      req_ifetch = ifc;
      req_shared = sh;
      @(posedge clk);
      #1;
   endtask

   // Expected instruction home from the grid rules of R6 and R8
   function automatic int model_inst(input int t, input int s);
      int x, y, r, d;
      x = t % 4; y = t / 4;
      r = (x + 2 * y) % 4;
      d = (s - r + 4) % 4;
      case (d)
         1: x = (x + 1) % 4;
         2: y = (y + 1) % 4;
         3: x = (x + 3) % 4;
         default: ;
      endcase
      return y * 4 + x;
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1 valid in reset", int'(dst_valid), 0);
      check("R1 tile in reset", int'(dst_tile), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1 valid after reset", int'(dst_valid), 0);
      check("R1 tile after reset", int'(dst_tile), 0);

      // Table of directed vectors (R3 R4 R5 R7 R8)
      for (int i = 0; i < NV; i++) begin
         send(V_TILE[i], V_SEL[i], V_IF[i], V_SH[i]);
         check("R2 valid", int'(dst_valid), 1);
         check(V_IF[i] ? (V_SH[i] ? "R5 shared fetch" : "R8 cluster pick")
                       : (V_SH[i] ? "R4 shared home" : "R3 private local"),
               int'(dst_tile), int'(V_EXP[i]));
      end

      // R6 R7 R8: sweep every tile against every rotation target
      for (int t = 0; t < 16; t++) begin
         for (int s = 0; s < 4; s++) begin
            send(4'(t), {2'b10, 2'(s)}, 1'b1, 1'(s & 1));
            check("R7 R8 sweep", int'(dst_tile), model_inst(t, s));
         end
      end

      // R4: shared home independent of requester
      send(4'd13, 4'h5, 1'b0, 1'b1);
      check("R4 shared ignores tile", int'(dst_tile), 5);

      // R9: idle cycle keeps tile, drops valid
      send(4'd7, 4'h0, 1'b0, 1'b0);
      @(negedge clk);
      req_valid = 1'b0;
      req_tile  = 4'd2;
      req_shared = 1'b1;
      @(posedge clk);
      #1;
      check("R9 valid drops", int'(dst_valid), 0);
      check("R9 tile holds", int'(dst_tile), 7);
      check("R2 no spurious valid", int'(dst_valid), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule